// File: doc/BRIEF.md
# Windowed Register File with Rotating Call Frames

This block is the integer register file of a pipeline whose procedure frames live in overlapping register windows. Each instruction names one of 32 architectural registers. A small mapper turns that index, together with the current window pointer, into a slot in a larger physical array. Eight globals are shared by every frame. The other 24 indices reach the active window. The callee's input group and the caller's output group are the same physical storage, so arguments and return values cross a frame boundary without being copied.

The decode stage issues save and restore commands, which rotate the window pointer. A call or return with no such command leaves the mapping unchanged. The block keeps a mask that marks some windows as not usable. If a rotation would land on a marked window, the block raises an overflow or underflow trap in the same cycle and leaves the pointer where it was. The trap handler, which sits outside this block, can then spill or fill registers and rewrite the mask through its load port. The block has two combinational read ports and one write port.

Top module: `win_regfile`

## Requirements
- R1: After reset, the window pointer is 0, the invalid mask has only bit 0 set, and every register reads zero.
- R2: Indices 0–7 select globals, 8–15 outs, 16–23 locals and 24–31 ins. A global reaches the same storage in every window, and the locals of each window are private to it.
- R3: Index 0 always reads zero, and a write to it changes nothing.
- R4: A save with no trap sets the pointer to (pointer − 1) mod NWIN. Out register k of the caller, including out 7 (the return address), then reads back as in register k.
- R5: A restore with no trap sets the pointer to (pointer + 1) mod NWIN. The caller's outs, locals and ins read back with the values they had before the matching save.
- R6: A save whose target window (pointer − 1 mod NWIN) has its mask bit set drives `ovf_trap` high in that same cycle, and leaves the pointer unchanged.
- R7: A restore whose target window (pointer + 1 mod NWIN) has its mask bit set drives `unf_trap` high in that same cycle, and leaves the pointer unchanged.
- R8: When save and restore are asserted together, the save is acted on and the restore is dropped. `unf_trap` stays low in that case.
- R9: `mask_we` loads `mask_din` into the mask at the next edge. A save or restore in that same cycle is checked against the old mask.
- R10: A read of the register being written in the same cycle returns the new write data, on either read port.
- R11: A save or restore changes the mapping only from the next cycle on. Reads and a write in the command cycle still use the old window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_a_idx | input | 5 | Architectural index, read port A |
| rd_a_data | output | DW | Read data, port A |
| rd_b_idx | input | 5 | Architectural index, read port B |
| rd_b_data | output | DW | Read data, port B |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Architectural index of the write |
| wr_data | input | DW | Write data |
| save_i | input | 1 | Rotate to the callee window |
| restore_i | input | 1 | Rotate back to the caller window |
| mask_we | input | 1 | Load the invalid mask |
| mask_din | input | NWIN | New invalid mask value |
| cwp_o | output | $clog2(NWIN) | Current window pointer |
| mask_o | output | NWIN | Current invalid mask |
| ovf_trap | output | 1 | Save refused: target window invalid |
| unf_trap | output | 1 | Restore refused: target window invalid |

## Verification
A register write and a window rotation can happen in the same cycle. The write must land in the old window, while the reads in that cycle also resolve through the old pointer and bypass the new data. The bench provokes this with directed cycles that write a local or out register while a save or restore is asserted. It also runs a long pseudo-random stream in which writes, rotations and mask loads coincide freely. Every read, trap flag, pointer and mask value is judged against an arithmetic model of the window mapping, which is updated only after each edge.

// File: rtl/wrf_pkg.sv
`timescale 1ns/1ps
// wrf_pkg: shared constants and types for the windowed register file.
// Assumes a 5-bit architectural index split into four groups of eight.
package wrf_pkg;
    localparam int GRP_SZ  = 8;
    localparam int NGLOB   = 8;
    localparam int WIN_SZ  = 2 * GRP_SZ;   // locals plus ins owned by a window
    localparam int IDX_W   = 5;

    typedef enum logic [1:0] {
        GRP_GLB = 2'd0,
        GRP_OUT = 2'd1,
        GRP_LOC = 2'd2,
        GRP_IN  = 2'd3
    } reg_grp_e;

    // Group selected by an architectural index.
    function automatic reg_grp_e grp_of(input logic [IDX_W-1:0] idx);
        return reg_grp_e'(idx[4:3]);
    endfunction
endpackage

// File: rtl/wrf_map.sv
`timescale 1ns/1ps
// wrf_map: maps an architectural index to a physical slot.
// Layout: slots 0..7 are globals. Window w owns 16 slots starting at
// 8+16*w: the ins first, then the locals. The outs of window w are the
// ins of window w-1 (mod NWIN).
module wrf_map #(
    parameter int NWIN = 8,
    parameter int CWPW = 3,
    parameter int PW   = 8
) (
    input  logic [4:0]      idx,
    input  logic [CWPW-1:0] cwp,
    output logic [PW-1:0]   phys
);
    import wrf_pkg::*;

    int unsigned cur_w;
    int unsigned prv_w;
    int unsigned off;

    // Select the owning window and the offset within it.
    always_comb begin
        cur_w = int'(cwp);
        prv_w = (cur_w == 0) ? NWIN - 1 : cur_w - 1;
        off   = int'(idx[2:0]);
        unique case (grp_of(idx))
            GRP_GLB: phys = PW'(off);
            GRP_OUT: phys = PW'(NGLOB + WIN_SZ * prv_w + off);
            GRP_LOC: phys = PW'(NGLOB + WIN_SZ * cur_w + GRP_SZ + off);
            default: phys = PW'(NGLOB + WIN_SZ * cur_w + off);
        endcase
    end
endmodule

// File: rtl/wrf_winctl.sv
`timescale 1ns/1ps
// wrf_winctl: window pointer and invalid mask, with trap detection.
// Save takes priority over restore. A trap blocks the rotation, and the
// trap check always uses the mask held before any load in the same cycle.
module wrf_winctl #(
    parameter int NWIN = 8,
    parameter int CWPW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            save_i,
    input  logic            restore_i,
    input  logic            mask_we,
    input  logic [NWIN-1:0] mask_din,
    output logic [CWPW-1:0] cwp,
    output logic [NWIN-1:0] mask,
    output logic            ovf,
    output logic            unf
);
    logic [CWPW-1:0] prv_w;
    logic [CWPW-1:0] nxt_w;
    logic            do_res;

    // Neighbour windows and trap decisions.
    always_comb begin
        prv_w  = (cwp == '0) ? CWPW'(NWIN - 1) : cwp - 1'b1;
        nxt_w  = (cwp == CWPW'(NWIN - 1)) ? '0 : cwp + 1'b1;
        do_res = restore_i && !save_i;
        ovf    = save_i && mask[prv_w];
        unf    = do_res && mask[nxt_w];
    end

    // Pointer rotation and mask load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cwp  <= '0;
            mask <= NWIN'(1);
        end else begin
            if (save_i && !ovf)
                cwp <= prv_w;
            else if (do_res && !unf)
                cwp <= nxt_w;
            if (mask_we)
                mask <= mask_din;
        end
    end
endmodule

// File: rtl/wrf_store.sv
`timescale 1ns/1ps
// wrf_store: physical register array with one write port and NRD read
// ports. Slot 0 is hard zero. A read of the slot being written returns
// the write data (write-first bypass).
module wrf_store #(
    parameter int NPHYS = 136,
    parameter int PW    = 8,
    parameter int DW    = 32,
    parameter int NRD   = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [PW-1:0]           wphys,
    input  logic [DW-1:0]           wdata,
    input  logic [NRD-1:0][PW-1:0]  rphys,
    output logic [NRD-1:0][DW-1:0]  rdata
);
    logic [DW-1:0] mem [NPHYS];

    // Clear on reset; write any slot but 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPHYS; i++) mem[i] <= '0;
        end else if (we && wphys != '0) begin
            mem[wphys] <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        // Zero slot, bypass, or stored value.
        always_comb begin
            if (rphys[p] == '0)
                rdata[p] = '0;
            else if (we && wphys == rphys[p])
                rdata[p] = wdata;
            else
                rdata[p] = mem[rphys[p]];
        end
    end
endmodule

// File: rtl/win_regfile.sv
`timescale 1ns/1ps
// win_regfile: overlapping windowed register file, two reads and one write.
// Assumes that decode drives save/restore for one cycle per command, and
// that the trap handler rewrites the mask through mask_we.
module win_regfile #(
    parameter int NWIN = 8,
    parameter int DW   = 32,
    localparam int CWPW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [4:0]      rd_a_idx,
    output logic [DW-1:0]   rd_a_data,
    input  logic [4:0]      rd_b_idx,
    output logic [DW-1:0]   rd_b_data,
    input  logic            wr_en,
    input  logic [4:0]      wr_idx,
    input  logic [DW-1:0]   wr_data,
    input  logic            save_i,
    input  logic            restore_i,
    input  logic            mask_we,
    input  logic [NWIN-1:0] mask_din,
    output logic [CWPW-1:0] cwp_o,
    output logic [NWIN-1:0] mask_o,
    output logic            ovf_trap,
    output logic            unf_trap
);
    import wrf_pkg::*;

    localparam int NPHYS = NGLOB + WIN_SZ * NWIN;
    localparam int PW    = $clog2(NPHYS);
    localparam int NPORT = 3;   // read A, read B, write

    logic [NPORT-1:0][4:0]    idx_all;
    logic [NPORT-1:0][PW-1:0] phys_all;
    logic [1:0][PW-1:0]       rphys;
    logic [1:0][DW-1:0]       rdata;

    // Collect all indices so one mapper per port can be generated.
    always_comb begin
        idx_all[0] = rd_a_idx;
        idx_all[1] = rd_b_idx;
        idx_all[2] = wr_idx;
        rphys[0]   = phys_all[0];
        rphys[1]   = phys_all[1];
        rd_a_data  = rdata[0];
        rd_b_data  = rdata[1];
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_map
        wrf_map #(.NWIN(NWIN), .CWPW(CWPW), .PW(PW)) u_map (
            .idx  (idx_all[p]),
            .cwp  (cwp_o),
            .phys (phys_all[p])
        );
    end

    wrf_winctl #(.NWIN(NWIN), .CWPW(CWPW)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .save_i    (save_i),
        .restore_i (restore_i),
        .mask_we   (mask_we),
        .mask_din  (mask_din),
        .cwp       (cwp_o),
        .mask      (mask_o),
        .ovf       (ovf_trap),
        .unf       (unf_trap)
    );

    wrf_store #(.NPHYS(NPHYS), .PW(PW), .DW(DW), .NRD(2)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .wphys (phys_all[2]),
        .wdata (wr_data),
        .rphys (rphys),
        .rdata (rdata)
    );
endmodule

// File: rtl/win_regfile_chk.sv
`timescale 1ns/1ps
// win_regfile_chk: port-level properties of win_regfile, attached by bind.
module win_regfile_chk #(
    parameter int NWIN = 8,
    parameter int DW   = 32,
    parameter int CWPW = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic [4:0]      rd_a_idx,
    input logic [DW-1:0]   rd_a_data,
    input logic [4:0]      rd_b_idx,
    input logic [DW-1:0]   rd_b_data,
    input logic            wr_en,
    input logic [4:0]      wr_idx,
    input logic [DW-1:0]   wr_data,
    input logic            save_i,
    input logic            restore_i,
    input logic [CWPW-1:0] cwp_o,
    input logic            ovf_trap,
    input logic            unf_trap
);
    a_r3_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == 5'd0) |-> (rd_a_data == '0));

    a_r4_save_step: assert property (@(posedge clk) disable iff (!rst_n)
        (save_i && !ovf_trap) |=>
        (cwp_o == (($past(cwp_o) == '0) ? CWPW'(NWIN - 1) : $past(cwp_o) - 1'b1)));

    a_r5_restore_step: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_i && !save_i && !unf_trap) |=>
        (cwp_o == (($past(cwp_o) == CWPW'(NWIN - 1)) ? '0 : $past(cwp_o) + 1'b1)));

    a_r6_ovf_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_trap |=> $stable(cwp_o));

    a_r7_unf_holds: assert property (@(posedge clk) disable iff (!rst_n)
        unf_trap |=> $stable(cwp_o));

    a_r8_save_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (save_i && restore_i) |-> !unf_trap);

    a_r11_idle_still: assert property (@(posedge clk) disable iff (!rst_n)
        (!save_i && !restore_i) |=> $stable(cwp_o));

    a_r10_bypass_b: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == rd_b_idx && wr_idx != 5'd0) |-> (rd_b_data == wr_data));
endmodule

bind win_regfile win_regfile_chk #(.NWIN(NWIN), .DW(DW), .CWPW(CWPW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_a_idx  (rd_a_idx),
    .rd_a_data (rd_a_data),
    .rd_b_idx  (rd_b_idx),
    .rd_b_data (rd_b_data),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .save_i    (save_i),
    .restore_i (restore_i),
    .cwp_o     (cwp_o),
    .ovf_trap  (ovf_trap),
    .unf_trap  (unf_trap)
);

// File: tb/tb_win_regfile.sv
`timescale 1ns/1ps
module tb_win_regfile;
    localparam int NW = 4;
    localparam int DW = 32;
    localparam int CW = 2;
    localparam int NP = 8 + 16 * NW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [DW-1:0] rd_a_data, rd_b_data, wr_data = '0;
    logic          wr_en = 1'b0, save_i = 1'b0, restore_i = 1'b0, mask_we = 1'b0;
    logic [NW-1:0] mask_din = '0, mask_o;
    logic [CW-1:0] cwp_o;
    logic          ovf_trap, unf_trap;

    always #2.5 clk = ~clk;

    win_regfile #(.NWIN(NW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .save_i(save_i), .restore_i(restore_i),
        .mask_we(mask_we), .mask_din(mask_din),
        .cwp_o(cwp_o), .mask_o(mask_o),
        .ovf_trap(ovf_trap), .unf_trap(unf_trap)
    );

    logic [DW-1:0] mdl [NP];
    int            mcwp;
    logic [NW-1:0] mmask;
    int            nchk = 0;
    int            nfail = 0;

    // Slot of an index in window w, following the R2/R4 layout.
    function automatic int slot(input int idx, input int w);
        int k = idx % 8;
        case (idx / 8)
            0:       return k;
            1:       return 8 + 16 * ((w + NW - 1) % NW) + k;
            2:       return 8 + 16 * w + 8 + k;
            default: return 8 + 16 * w + k;
        endcase
    endfunction

    function automatic logic [DW-1:0] exp_rd(input int idx);
        if (idx == 0) return '0;
        if (wr_en && wr_idx != 0 && slot(int'(wr_idx), mcwp) == slot(idx, mcwp))
            return wr_data;
        return mdl[slot(idx, mcwp)];
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Inputs are set; check outputs, then advance one edge and the model.
    task automatic cyc(input string tag);
        int pw = (mcwp + NW - 1) % NW;
        int nw = (mcwp + 1) % NW;
        logic eo, eu;
        #1;
        eo = save_i && mmask[pw];
        eu = restore_i && !save_i && mmask[nw];
        chk(tag, rd_a_data, exp_rd(int'(rd_a_idx)));
        chk(tag, rd_b_data, exp_rd(int'(rd_b_idx)));
        chk("R6", DW'(ovf_trap), DW'(eo));
        chk("R7", DW'(unf_trap), DW'(eu));
        chk(tag, DW'(cwp_o), DW'(mcwp));
        chk("R9", DW'(mask_o), DW'(mmask));
        @(posedge clk);
        if (wr_en && wr_idx != 0) mdl[slot(int'(wr_idx), mcwp)] = wr_data;
        if (save_i) begin
            if (!eo) mcwp = pw;
        end else if (restore_i) begin
            if (!eu) mcwp = nw;
        end
        if (mask_we) mmask = mask_din;
        @(negedge clk);
        wr_en = 0; save_i = 0; restore_i = 0; mask_we = 0;
    endtask

    task automatic wr(input int idx, input logic [DW-1:0] d, input string tag);
        wr_en = 1; wr_idx = 5'(idx); wr_data = d; cyc(tag);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        nfail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NP; i++) mdl[i] = '0;
        mcwp = 0; mmask = NW'(1);
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state over every index on both ports
        for (int i = 0; i < 32; i++) begin
            rd_a_idx = 5'(i); rd_b_idx = 5'(31 - i); cyc("R1");
        end
        chk("R1", DW'(mask_o), DW'(1));
        // R3: write to index 0 has no effect
        rd_a_idx = 0; rd_b_idx = 0; wr(0, 32'hFFFF_FFFF, "R3");
        cyc("R3");
        chk("R3", rd_b_data, '0);
        // clear mask, fill globals, then check they survive a rotation (R2)
        mask_we = 1; mask_din = '0; cyc("R9");
        for (int i = 1; i < 8; i++) wr(i, 32'h100 + i, "R2");
        wr(16, 32'hA0, "R2");
        save_i = 1; cyc("R4");
        for (int i = 1; i < 8; i++) begin
            rd_a_idx = 5'(i); rd_b_idx = 16; cyc("R2");
            chk("R2", rd_a_data, 32'h100 + i);
        end
        restore_i = 1; cyc("R5");
        // R4: out 1 and out 7 become in 1 and in 7; R11: write during save
        wr(9, 32'h11, "R4");
        wr(15, 32'h77, "R4");
        save_i = 1; wr(17, 32'h55, "R11");
        rd_a_idx = 25; rd_b_idx = 31; cyc("R4");
        chk("R4", rd_a_data, 32'h11);
        chk("R4", rd_b_data, 32'h77);
        rd_a_idx = 17; cyc("R11");
        chk("R11", rd_a_data, 32'h0);
        wr(9, 32'hDEAD, "R4");
        // R5: restore returns the caller view unchanged
        restore_i = 1; cyc("R5");
        rd_a_idx = 9; rd_b_idx = 17; cyc("R5");
        chk("R5", rd_a_data, 32'h11);
        chk("R5", rd_b_data, 32'h55);
        // R6: save into invalid window (pointer 0, target 3)
        mask_we = 1; mask_din = 4'b1000; cyc("R9");
        save_i = 1; cyc("R6");
        chk("R6", DW'(cwp_o), 0);
        // R7: restore into invalid window (target 1)
        mask_we = 1; mask_din = 4'b0010; cyc("R9");
        restore_i = 1; cyc("R7");
        chk("R7", DW'(cwp_o), 0);
        // R8: save and restore together; save acts
        mask_we = 1; mask_din = '0; cyc("R9");
        save_i = 1; restore_i = 1; cyc("R8");
        chk("R8", DW'(cwp_o), 3);
        // R9: mask load with save in the same cycle uses old mask
        save_i = 1; mask_we = 1; mask_din = 4'b0100; cyc("R9");
        chk("R9", DW'(cwp_o), 2);
        mask_we = 1; mask_din = '0; cyc("R9");
        // R10: bypass on both ports
        rd_a_idx = 20; rd_b_idx = 20; wr(20, 32'hBEEF, "R10");
        // sweep every window: write all groups, rotate through
        for (int w = 0; w < 2 * NW; w++) begin
            for (int i = 1; i < 32; i++) begin
                rd_a_idx = 5'(i); rd_b_idx = 5'(32 - i);
                wr(i, DW'(w * 1000 + i), "R2");
            end
            save_i = 1; cyc("R4");
        end
        for (int w = 0; w < 2 * NW; w++) begin
            for (int i = 0; i < 32; i++) begin
                rd_a_idx = 5'(i); rd_b_idx = 5'((i + 8) % 32); cyc("R5");
            end
            restore_i = 1; cyc("R5");
        end
        // pseudo-random mix of everything
        for (int n = 0; n < 6000; n++) begin
            rd_a_idx  = 5'($urandom_range(0, 31));
            rd_b_idx  = ($urandom_range(0, 3) == 0) ? wr_idx : 5'($urandom_range(0, 31));
            wr_en     = 1'($urandom_range(0, 1));
            wr_idx    = ($urandom_range(0, 3) == 0) ? rd_a_idx : 5'($urandom_range(0, 31));
            wr_data   = $urandom();
            save_i    = ($urandom_range(0, 5) == 0);
            restore_i = ($urandom_range(0, 5) == 0);
            mask_we   = ($urandom_range(0, 15) == 0);
            mask_din  = NW'($urandom_range(0, 15)) & NW'($urandom_range(0, 15));
            cyc("R10");
        end
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule